// File: doc/BRIEF.md
# Display Mode Control Register

This block holds the display configuration and the LED output latch of a dot-matrix LCD controller. A serial front end delivers each received command byte together with a decoded command kind. The block keeps the display mode: the duty cycle, whether the chip runs as master or slave, and whether the LCD drive voltage comes from outside or is generated inside. It also holds three run-state bits: LCD enabled, LEDs enabled and key scan running. A 4-bit LED latch drives open-drain pads through active-low output enables.

A mode command that changes the stored mode also switches the LCD off, switches the LEDs on and stops key scan. A mode command that repeats the stored mode does nothing. The duty selection decides whether the five shared pins act as commons or as segments. In 1/15 duty it also masks the four highest display RAM segment positions. An external active-low LCD-off input blanks the display whatever the registers hold. All outputs are registered and update on the rising clock edge that samples the command.

Top module: `lcd_mode_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, every output takes its reset value after that edge: `duty_15`, `slave_sel` and `supply_int` are 0, `dual_com` is all 0, `seg_en` is all 1, `lcd_on` is 0, `led_on` is 1, `key_scan_on` is 0 and `led_oe_n` is all 1.
- R2: A mode command (`cmd_kind` = 2'b00) whose bits [2:0] differ from the stored mode stores them. Bit 0 is the duty (1 = 1/15), bit 1 is slave (1 = slave) and bit 2 is the internal drive supply (1 = internal). Bits [7:3] are ignored.
- R3: A mode command that changes the stored mode also clears `lcd_on` and `key_scan_on` and sets `led_on`.
- R4: A mode command whose bits [2:0] equal the stored mode changes no output.
- R5: Every bit of `dual_com` equals `duty_15`: the shared pins act as commons in 1/15 duty and as segments in 1/8 duty.
- R6: `seg_en` bit i enables display RAM segment position i+1. In 1/15 duty bits 60 to 63 (positions 61 to 64) are 0. All other bits are 1.
- R7: An LED command (`cmd_kind` = 2'b10) loads bits [3:0] into the LED latch, bit i for LED i. Bits [7:4] are ignored.
- R8: `led_oe_n[i]` is 0 exactly when latch bit i is 1 and `led_on` is 1.
- R9: A status command (`cmd_kind` = 2'b01) sets the LCD enable from bit 0, `led_on` from bit 1 and `key_scan_on` from bit 2.
- R10: `lcd_on` is 1 only when the LCD enable is set and `lcd_off_n` was high at the same edge. A low `lcd_off_n` forces `lcd_on` to 0.
- R11: With `cmd_valid` low, or with `cmd_kind` = 2'b11, no stored state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command byte present this cycle |
| cmd_kind | input | 2 | Command kind: 00 mode, 01 status, 10 LED, 11 other |
| cmd_byte | input | 8 | Command data byte |
| lcd_off_n | input | 1 | Forced LCD blank, active low |
| duty_15 | output | 1 | 1 = 1/15 duty, 0 = 1/8 duty |
| slave_sel | output | 1 | 1 = slave, 0 = master |
| supply_int | output | 1 | 1 = internal drive supply, 0 = external |
| dual_com | output | 5 | Per shared pin: 1 = common, 0 = segment |
| seg_en | output | 64 | Per display RAM segment position: 1 = enabled |
| lcd_on | output | 1 | Effective LCD enable after the forced blank |
| led_on | output | 1 | LED enable state |
| key_scan_on | output | 1 | Key scan running |
| led_oe_n | output | 4 | Active-low enables for the open-drain LED pads |

## Verification
Every result is due one rising edge after the command or input that causes it, because each output comes from a single register stage. This also covers `lcd_on` responding to `lcd_off_n`. The bench changes its inputs on the falling edge and lets one rising edge pass. It then compares all outputs against a behavioural model on the following falling edge, so each comparison falls on the cycle in which the result is due. Repeated mode commands and ignored command kinds are checked the same way, by confirming that nothing moved at that cycle.

// File: rtl/lcd_mode_pkg.sv
package lcd_mode_pkg;

  typedef enum logic [1:0] {
    CMD_MODE   = 2'b00,
    CMD_STATUS = 2'b01,
    CMD_LED    = 2'b10,
    CMD_OTHER  = 2'b11
  } cmd_kind_e;

  // Display mode bits, ordered as they arrive in the command byte [2:0]
  typedef struct packed {
    logic supply_int;
    logic slave;
    logic duty15;
  } mode_t;

  // Run state bits, ordered as they arrive in the status byte [2:0]
  typedef struct packed {
    logic key_scan;
    logic led_en;
    logic lcd_en;
  } run_t;

  localparam mode_t MODE_RESET = '{supply_int: 1'b0, slave: 1'b0, duty15: 1'b0};
  localparam run_t  RUN_RESET  = '{key_scan: 1'b0, led_en: 1'b1, lcd_en: 1'b0};
  localparam run_t  RUN_ON_MODE_CHANGE = '{key_scan: 1'b0, led_en: 1'b1, lcd_en: 1'b0};

endpackage

// File: rtl/lcd_mode_decode.sv
module lcd_mode_decode
  import lcd_mode_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic             cmd_valid,
  input  cmd_kind_e        cmd_kind,
  input  logic [CMD_W-1:0] cmd_byte,
  input  mode_t            mode_q,
  input  run_t             run_q,
  output mode_t            mode_d,
  output run_t             run_d,
  output logic             led_load
);

  mode_t req_mode;

  always_comb begin
    req_mode = mode_t'(cmd_byte[2:0]);
    mode_d   = mode_q;
    run_d    = run_q;
    led_load = 1'b0;
    if (cmd_valid) begin
      unique case (cmd_kind)
        CMD_MODE: begin
          if (req_mode != mode_q) begin
            mode_d = req_mode;
            run_d  = RUN_ON_MODE_CHANGE;
          end
        end
        CMD_STATUS: run_d    = run_t'(cmd_byte[2:0]);
        CMD_LED:    led_load = 1'b1;
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/lcd_led_latch.sv
module lcd_led_latch #(
  parameter int CMD_W = 8,
  parameter int N_LED = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CMD_W-1:0] data,
  input  logic             led_en_d,
  output logic [N_LED-1:0] latch_q,
  output logic [N_LED-1:0] oe_n
);

  logic [N_LED-1:0] latch_d;

  always_comb begin
    latch_d = load ? data[N_LED-1:0] : latch_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      oe_n    <= '1;
    end else begin
      latch_q <= latch_d;
      oe_n    <= ~(latch_d & {N_LED{led_en_d}});
    end
  end

  // A pad is pulled low only for a bit the latch holds
  AST_OE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (rst)
    ((~oe_n & ~latch_q) == '0)); // R8

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(latch_q)); // R7

endmodule

// File: rtl/lcd_pin_cfg.sv
module lcd_pin_cfg #(
  parameter int N_DUAL      = 5,
  parameter int N_SEG       = 64,
  parameter int SEG_KEEP_15 = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              duty15_d,
  output logic [N_DUAL-1:0] dual_com,
  output logic [N_SEG-1:0]  seg_en
);

  always_ff @(posedge clk) begin
    if (rst) dual_com <= '0;
    else     dual_com <= {N_DUAL{duty15_d}};
  end

  for (genvar i = 0; i < N_SEG; i++) begin : g_seg
    if (i < SEG_KEEP_15) begin : g_keep
      always_ff @(posedge clk) seg_en[i] <= 1'b1;
    end else begin : g_cut
      always_ff @(posedge clk) begin
        if (rst) seg_en[i] <= 1'b1;
        else     seg_en[i] <= ~duty15_d;
      end
    end
  end

  if (SEG_KEEP_15 < N_SEG) begin : g_chk
    AST_SEG_CUT_VS_COM: assert property (@(posedge clk) disable iff (rst)
      seg_en[N_SEG-1] == !dual_com[0]); // R6
  end

endmodule

// File: rtl/lcd_mode_ctrl.sv
module lcd_mode_ctrl
  import lcd_mode_pkg::*;
#(
  parameter int CMD_W       = 8,
  parameter int N_LED       = 4,
  parameter int N_DUAL      = 5,
  parameter int N_SEG       = 64,
  parameter int SEG_KEEP_15 = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_kind,
  input  logic [CMD_W-1:0]  cmd_byte,
  input  logic              lcd_off_n,
  output logic              duty_15,
  output logic              slave_sel,
  output logic              supply_int,
  output logic [N_DUAL-1:0] dual_com,
  output logic [N_SEG-1:0]  seg_en,
  output logic              lcd_on,
  output logic              led_on,
  output logic              key_scan_on,
  output logic [N_LED-1:0]  led_oe_n
);

  mode_t            mode_q, mode_d;
  run_t             run_q, run_d;
  logic             led_load;
  logic             lcd_on_q;
  logic [N_LED-1:0] latch_q;
  cmd_kind_e        kind;

  assign kind = cmd_kind_e'(cmd_kind);

  lcd_mode_decode #(.CMD_W(CMD_W)) u_decode (
    .cmd_valid (cmd_valid),
    .cmd_kind  (kind),
    .cmd_byte  (cmd_byte),
    .mode_q    (mode_q),
    .run_q     (run_q),
    .mode_d    (mode_d),
    .run_d     (run_d),
    .led_load  (led_load)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_RESET;
      run_q    <= RUN_RESET;
      lcd_on_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      run_q    <= run_d;
      lcd_on_q <= run_d.lcd_en & lcd_off_n;
    end
  end

  lcd_led_latch #(.CMD_W(CMD_W), .N_LED(N_LED)) u_led (
    .clk      (clk),
    .rst      (rst),
    .load     (led_load),
    .data     (cmd_byte),
    .led_en_d (run_d.led_en),
    .latch_q  (latch_q),
    .oe_n     (led_oe_n)
  );

  lcd_pin_cfg #(.N_DUAL(N_DUAL), .N_SEG(N_SEG), .SEG_KEEP_15(SEG_KEEP_15)) u_pins (
    .clk      (clk),
    .rst      (rst),
    .duty15_d (mode_d.duty15),
    .dual_com (dual_com),
    .seg_en   (seg_en)
  );

  assign duty_15     = mode_q.duty15;
  assign slave_sel   = mode_q.slave;
  assign supply_int  = mode_q.supply_int;
  assign lcd_on      = lcd_on_q;
  assign led_on      = run_q.led_en;
  assign key_scan_on = run_q.key_scan;

  AST_MODE_CHANGE_SIDE: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && kind == CMD_MODE && cmd_byte[2:0] != mode_q)
      |=> (!lcd_on && led_on && !key_scan_on)); // R3

  AST_SAME_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && kind == CMD_MODE && cmd_byte[2:0] == mode_q)
      |=> ($stable(mode_q) && $stable(run_q) && $stable(latch_q))); // R4

  AST_DUAL_FOLLOWS_DUTY: assert property (@(posedge clk) disable iff (rst)
    dual_com == {N_DUAL{duty_15}}); // R5

  AST_LCD_OFF_FORCE: assert property (@(posedge clk) disable iff (rst)
    !lcd_off_n |=> !lcd_on); // R10

  AST_LED_DISABLED_DARK: assert property (@(posedge clk) disable iff (rst)
    !led_on |-> (&led_oe_n)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cmd_valid || kind == CMD_OTHER)
      |=> ($stable(mode_q) && $stable(run_q) && $stable(latch_q))); // R11

endmodule

// File: tb/lcd_mode_ctrl_tb.sv
module lcd_mode_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N_SEG  = 64;
  localparam int N_DUAL = 5;
  localparam int N_LED  = 4;
  localparam int KEEP15 = 60;

  logic              clk = 1'b0;
  logic              rst;
  logic              cmd_valid;
  logic [1:0]        cmd_kind;
  logic [7:0]        cmd_byte;
  logic              lcd_off_n;
  logic              duty_15, slave_sel, supply_int, lcd_on, led_on, key_scan_on;
  logic [N_DUAL-1:0] dual_com;
  logic [N_SEG-1:0]  seg_en;
  logic [N_LED-1:0]  led_oe_n;

  int n_tests = 0;
  int n_fail  = 0;

  // behavioural reference state
  int m_duty, m_slave, m_supply, m_lcd, m_led, m_key, m_latch, m_lcd_on;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_mode_ctrl u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_byte(cmd_byte), .lcd_off_n(lcd_off_n), .duty_15(duty_15),
    .slave_sel(slave_sel), .supply_int(supply_int), .dual_com(dual_com),
    .seg_en(seg_en), .lcd_on(lcd_on), .led_on(led_on),
    .key_scan_on(key_scan_on), .led_oe_n(led_oe_n)
  );

  task automatic check(input string tag, input string field,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, field, act, exp);
    end
  endtask

  task automatic model_update(input logic r, input logic v, input logic [1:0] k,
                              input logic [7:0] b, input logic offn);
    if (r) begin
      m_duty = 0; m_slave = 0; m_supply = 0;
      m_lcd = 0; m_led = 1; m_key = 0; m_latch = 0; m_lcd_on = 0;
    end else begin
      if (v) begin
        if (k == 2'b00) begin
          if (b[0] != m_duty[0] || b[1] != m_slave[0] || b[2] != m_supply[0]) begin
            m_duty = b[0]; m_slave = b[1]; m_supply = b[2];
            m_lcd = 0; m_led = 1; m_key = 0;
          end
        end else if (k == 2'b01) begin
          m_lcd = b[0]; m_led = b[1]; m_key = b[2];
        end else if (k == 2'b10) begin
          m_latch = b & 8'h0F;
        end
      end
      m_lcd_on = (m_lcd != 0 && offn) ? 1 : 0;
    end
  endtask

  task automatic compare_all(input string tag);
    logic [63:0] e_seg;
    logic [3:0]  e_oe;
    e_seg = '1;
    if (m_duty != 0)
      for (int i = KEEP15; i < N_SEG; i++) e_seg[i] = 1'b0;
    e_oe = ~(m_latch[3:0] & {4{m_led != 0}});
    check({tag, " R2"},  "duty_15",     64'(duty_15),    64'(m_duty));
    check({tag, " R2"},  "slave_sel",   64'(slave_sel),  64'(m_slave));
    check({tag, " R2"},  "supply_int",  64'(supply_int), 64'(m_supply));
    check({tag, " R5"},  "dual_com",    64'(dual_com),   (m_duty != 0) ? 64'h1F : 64'h0);
    check({tag, " R6"},  "seg_en",      seg_en,          e_seg);
    check({tag, " R10"}, "lcd_on",      64'(lcd_on),     64'(m_lcd_on));
    check({tag, " R3"},  "led_on",      64'(led_on),     64'(m_led));
    check({tag, " R9"},  "key_scan_on", 64'(key_scan_on), 64'(m_key));
    check({tag, " R8"},  "led_oe_n",    64'(led_oe_n),   64'(e_oe));
  endtask

  // called at a falling edge: drive, let one rising edge pass, compare
  task automatic step(input logic r, input logic v, input logic [1:0] k,
                      input logic [7:0] b, input logic offn, input string tag);
    rst = r; cmd_valid = v; cmd_kind = k; cmd_byte = b; lcd_off_n = offn;
    @(posedge clk);
    model_update(r, v, k, b, offn);
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_kind = 2'b00; cmd_byte = 8'h00; lcd_off_n = 1'b1;
    m_duty = 0; m_slave = 0; m_supply = 0; m_lcd = 0; m_led = 1;
    m_key = 0; m_latch = 0; m_lcd_on = 0;
    @(negedge clk);
    step(1, 0, 2'b00, 8'h00, 1, "R1 reset");
    step(1, 1, 2'b01, 8'h07, 1, "R1 reset beats status");
    step(0, 0, 2'b00, 8'h00, 1, "R11 idle after reset");
    step(0, 1, 2'b01, 8'h07, 1, "R9 status all on");
    step(0, 1, 2'b00, 8'hF8, 1, "R4 same mode upper bits set");
    step(0, 1, 2'b10, 8'hA5, 1, "R7 led latch upper ignored");
    step(0, 1, 2'b00, 8'hF9, 1, "R3 mode change to 1/15");
    step(0, 1, 2'b01, 8'h07, 1, "R9 status restart");
    step(0, 1, 2'b00, 8'h01, 1, "R4 same mode 1/15");
    step(0, 1, 2'b01, 8'h05, 1, "R8 leds disabled");
    step(0, 1, 2'b10, 8'h0F, 1, "R8 latch full while disabled");
    step(0, 1, 2'b01, 8'h03, 1, "R9 leds on key off");
    step(0, 0, 2'b00, 8'h06, 1, "R11 invalid mode byte");
    step(0, 1, 2'b11, 8'h06, 1, "R11 other kind");
    step(0, 1, 2'b00, 8'h06, 1, "R2 slave internal 1/8");
    step(0, 1, 2'b01, 8'h07, 0, "R10 forced blank");
    step(0, 0, 2'b00, 8'h00, 0, "R10 blank held");
    step(0, 0, 2'b00, 8'h00, 1, "R10 blank released");
    step(0, 1, 2'b10, 8'h36, 1, "R7 second pattern");
    step(0, 1, 2'b00, 8'h03, 1, "R6 1/15 slave external");
    step(1, 0, 2'b00, 8'h00, 1, "R1 reset mid run");
    step(0, 1, 2'b00, 8'h00, 1, "R4 same as reset mode");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule